// File: doc/BRIEF.md
# SDRAM Data Path with CAS Latency and Byte Masking

This block is the data-side half of an SDRAM controller for a 32-bit memory bus. The command sequencer marks each column beat with a read strobe or a write strobe. On a read, the block waits the programmed CAS latency and then captures the word on the DQ input bus. It returns that word with a valid flag and a per-byte valid vector. On a write, the block drives the DQ bus and enables the bus driver in the same cycle as the beat. It also produces the four byte-mask lines, each covering one byte lane.

The two kinds of mask are timed differently. A write mask applies to the data in the cycle where it is sampled. A read mask only takes effect two clocks after it is sampled, so the block issues read masks ahead of the data slot and zeroes the masked lanes of the captured word itself. A write-recovery flag tells the sequencer when enough cycles have passed since the last write beat for a precharge to be issued.

Top module: `sdram_dq_path`

## Requirements
- R1: A read beat in cycle t causes the dq_in value present during cycle t+CL to appear on rd_data, with rd_valid high, in cycle t+CL+1. Here CL is the effective CAS latency.
- R2: cas_lat values 1, 2 and 3 select a CAS latency of 1, 2 and 3 cycles. The value 0 behaves as a latency of 1.
- R3: Bit i of a byte-enable vector refers to data bits 8i+7:8i. With rd_valid, rd_lane_valid equals the rd_byte_en of that beat, and every lane not enabled reads as zero.
- R4: For a read beat in cycle t, dqm[i] is high for each lane whose enable is clear. This happens in cycle t+CL-2 when CL is 2 or 3, and in cycle t when CL is 1. Without a read or write mask due, dqm is zero.
- R5: dq_oe is high exactly in write-beat cycles. dq_out equals wr_data in those cycles and is zero otherwise.
- R6: During a write beat, dqm[i] is the inverse of wr_byte_en[i] in that same cycle.
- R7: When a write beat and a due read mask fall in the same cycle, dqm is the bitwise OR of both masks.
- R8: wr_recovered is low in a write-beat cycle and in the cycle after it. It is high from the second cycle after the last write beat onward.
- R9: While reset is asserted, rd_valid, rd_lane_valid, rd_data, dq_oe and dqm are zero and wr_recovered is high.
- R10: Read beats in consecutive cycles each produce their own rd_valid cycle, with no beat lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat | input | 2 | CAS latency select |
| rd_beat | input | 1 | Read column beat strobe |
| rd_byte_en | input | 4 | Lanes wanted by this read beat |
| wr_beat | input | 1 | Write column beat strobe |
| wr_byte_en | input | 4 | Lanes written by this write beat |
| wr_data | input | 32 | Write data for this beat |
| dq_in | input | 32 | Data bus from the memory |
| dq_out | output | 32 | Data bus to the memory |
| dq_oe | output | 1 | Data bus driver enable |
| dqm | output | 4 | Byte-mask lines to the memory |
| rd_valid | output | 1 | Captured read word valid |
| rd_data | output | 32 | Captured read word, masked lanes zero |
| rd_lane_valid | output | 4 | Per-lane valid for rd_data |
| wr_recovered | output | 1 | Write recovery window has elapsed |

## Verification
Read masks and write masks can meet on the dqm lines in the same cycle. At a latency of 3, the mask for the previous cycle's read is due while a new write beat drives its own mask. A pseudo-random stream of overlapping read and write beats at every latency setting provokes this collision. Each cycle's dqm is compared with the OR of the two masks that the bench derives from its own beat history. The same stream also checks read capture against a known data pattern on dq_in.

// File: rtl/sdram_dq_path.sv
module sdram_dq_path #(
  parameter int DATA_W      = 32,
  parameter int MAX_CL      = 3,
  parameter int WR_RECOVERY = 2,
  localparam int LANES      = DATA_W / 8,
  localparam int CW         = $clog2(WR_RECOVERY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_lat,
  input  logic              rd_beat,
  input  logic [LANES-1:0]  rd_byte_en,
  input  logic              wr_beat,
  input  logic [LANES-1:0]  wr_byte_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [LANES-1:0]  dqm,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [LANES-1:0]  rd_lane_valid,
  output logic              wr_recovered
);

  logic [1:0]       cl_eff;
  logic [MAX_CL-1:0] pv;
  logic [LANES-1:0] pbe [MAX_CL];
  logic             tap_v;
  logic [LANES-1:0] tap_be;
  logic [DATA_W-1:0] tap_mask;
  logic [LANES-1:0] rd_mask, wr_mask;
  logic [CW-1:0]    since_wr;

  assign cl_eff = (cas_lat == 2'd0) ? 2'd1 : cas_lat;
  assign tap_v  = pv[cl_eff - 2'd1];
  assign tap_be = pbe[cl_eff - 2'd1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign tap_mask[g*8 +: 8] = {8{tap_be[g]}};
  end

  always_comb begin
    rd_mask = '0;
    if (cl_eff <= 2'd2) begin
      if (rd_beat) rd_mask = ~rd_byte_en;
    end else if (pv[cl_eff - 2'd3]) begin
      rd_mask = ~pbe[cl_eff - 2'd3];
    end
  end

  assign wr_mask = wr_beat ? ~wr_byte_en : '0;
  assign dqm     = rst_n ? (rd_mask | wr_mask) : '0;
  assign dq_oe   = rst_n & wr_beat;
  assign dq_out  = dq_oe ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      for (int k = 0; k < MAX_CL; k++) pbe[k] <= '0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      rd_lane_valid <= '0;
    end else begin
      pv     <= {pv[MAX_CL-2:0], rd_beat};
      pbe[0] <= rd_byte_en;
      for (int k = 1; k < MAX_CL; k++) pbe[k] <= pbe[k-1];
      rd_valid      <= tap_v;
      rd_lane_valid <= tap_v ? tap_be : '0;
      rd_data       <= tap_v ? (dq_in & tap_mask) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      since_wr <= CW'(WR_RECOVERY);
    else if (wr_beat)                since_wr <= CW'(1);
    else if (since_wr < WR_RECOVERY) since_wr <= since_wr + CW'(1);
  end

  assign wr_recovered = !dq_oe && (since_wr >= CW'(WR_RECOVERY));

endmodule

module sdram_dq_path_sva #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cas_lat,
  input logic              rd_beat,
  input logic              wr_beat,
  input logic [LANES-1:0]  wr_byte_en,
  input logic [LANES-1:0]  dqm,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [LANES-1:0]  rd_lane_valid,
  input logic              wr_recovered
);

  assert_rd_lat1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cas_lat <= 2'd1 && $past(cas_lat, 2) <= 2'd1) |-> $past(rd_beat, 2));
  assert_rd_lat2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cas_lat == 2'd2 && $past(cas_lat, 3) == 2'd2) |-> $past(rd_beat, 3));
  assert_rd_lat3_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && cas_lat == 2'd3 && $past(cas_lat, 4) == 2'd3) |-> $past(rd_beat, 4));
  assert_lane_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_lane_valid) |-> rd_valid);
  assert_wr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat |-> ((dqm | wr_byte_en) == '1));
  assert_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_beat) |-> !wr_recovered);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    assert_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lane_valid[g] |-> (rd_data[g*8 +: 8] == 8'd0));
  end

endmodule

bind sdram_dq_path sdram_dq_path_sva #(.DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_beat(rd_beat),
  .wr_beat(wr_beat), .wr_byte_en(wr_byte_en), .dqm(dqm),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_lane_valid(rd_lane_valid),
  .wr_recovered(wr_recovered)
);

// File: tb/sdram_dq_path_bench.sv
module sdram_dq_path_bench;
  localparam int N = 8192;

  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  cas_lat = 2'd1;
  logic        rd_beat = 1'b0, wr_beat = 1'b0;
  logic [3:0]  rd_byte_en = '0, wr_byte_en = '0;
  logic [31:0] wr_data = '0, dq_in = '0;
  logic [31:0] dq_out, rd_data;
  logic        dq_oe, rd_valid, wr_recovered;
  logic [3:0]  dqm, rd_lane_valid;

  sdram_dq_path u_sdram_dq_path (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_beat(rd_beat),
    .rd_byte_en(rd_byte_en), .wr_beat(wr_beat), .wr_byte_en(wr_byte_en),
    .wr_data(wr_data), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .dqm(dqm), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_lane_valid(rd_lane_valid), .wr_recovered(wr_recovered)
  );

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  bit       hr [N];
  bit       hw [N];
  bit [3:0] hrbe [N];
  logic [15:0] lf = 16'hACE1;

  function automatic logic [31:0] pat(int c);
    return (32'(c) * 32'h0103_0507) ^ 32'hA5C3_0F96;
  endfunction

  function automatic logic [31:0] expand(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", req, what, n, act, exp);
    end
  endtask

  task automatic cyc(bit r, logic [3:0] rbe, bit w, logic [3:0] wbe, int cl);
    int e, b;
    logic ev;
    logic [3:0] ebe, rm, wm;
    logic [31:0] wd;
    @(negedge clk);
    e  = (cl == 0) ? 1 : cl;
    wd = pat(n) ^ 32'h5A5A_3C3C;
    cas_lat = 2'(cl); rd_beat = r; rd_byte_en = rbe;
    wr_beat = w; wr_byte_en = wbe; wr_data = wd; dq_in = pat(n);
    hr[n] = r; hrbe[n] = rbe; hw[n] = w;
    #1;
    b   = n - 1 - e;
    ev  = (b >= 0) ? hr[b] : 1'b0;
    ebe = ev ? hrbe[b] : 4'd0;
    chk(cl == 0 ? "R2" : (n > 0 && hr[n-1] && r ? "R10" : "R1"), "rd_valid", 32'(rd_valid), 32'(ev));
    chk("R3", "rd_lane_valid", 32'(rd_lane_valid), 32'(ebe));
    chk("R1", "rd_data", rd_data, ev ? (pat(n-1) & expand(ebe)) : 32'd0);
    if (e <= 2) rm = r ? ~rbe : 4'd0;
    else        rm = (n >= 1 && hr[n-1]) ? ~hrbe[n-1] : 4'd0;
    wm = w ? ~wbe : 4'd0;
    chk((w && rm != 0) ? "R7" : (w ? "R6" : "R4"), "dqm", 32'(dqm), 32'(rm | wm));
    chk("R5", "dq_oe", 32'(dq_oe), 32'(w));
    chk("R5", "dq_out", dq_out, w ? wd : 32'd0);
    chk("R8", "wr_recovered", 32'(wr_recovered), 32'(!w && !(n >= 1 && hw[n-1])));
    n++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "reset rd_valid", 32'(rd_valid), 32'd0);
    chk("R9", "reset rd_data", rd_data, 32'd0);
    chk("R9", "reset rd_lane_valid", 32'(rd_lane_valid), 32'd0);
    chk("R9", "reset dq_oe", 32'(dq_oe), 32'd0);
    chk("R9", "reset dqm", 32'(dqm), 32'd0);
    chk("R9", "reset wr_recovered", 32'(wr_recovered), 32'd1);
    rst_n = 1'b1;
    for (int cl = 0; cl < 4; cl++) begin
      repeat (6) cyc(0, 0, 0, 0, cl);
      for (int k = 0; k < 16; k++) begin
        cyc(1, 4'(k), 0, 0, cl);
        cyc(0, 0, 0, 0, cl);
      end
      repeat (5) cyc(0, 0, 0, 0, cl);
      for (int k = 0; k < 8; k++) cyc(1, 4'(k) ^ 4'h9, 0, 0, cl);
      repeat (5) cyc(0, 0, 0, 0, cl);
      for (int k = 0; k < 16; k++) begin
        cyc(0, 0, 1, 4'(k), cl);
        if (k % 2 == 1) cyc(0, 0, 0, 0, cl);
      end
      repeat (3) cyc(0, 0, 0, 0, cl);
      for (int k = 0; k < 200; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc(lf[0], lf[7:4], lf[1] & lf[2], lf[11:8], cl);
      end
      repeat (6) cyc(0, 0, 0, 0, cl);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule